// File: doc/BRIEF.md
# Stepped Digital Receive Volume Scaler

This block scales decoded 13-bit two's-complement receive samples on their way to the playback path. Each linear sample arrives with its own 3-bit gain code. The code picks one of eight gains, from +3 dB down to -18 dB in 3 dB steps. The gain is applied as a Q2.14 fixed-point multiplier. The product is rounded to the nearest integer and clamped to the 13-bit range.

When the companded-mode select is high, the code that comes with the sample is disregarded and unity gain is used. A mute input forces the output to exactly zero. The valid strobe still passes through while muted, so the downstream sample timing is kept. Every sample leaves a fixed two clock cycles after it was presented. The output sample register holds its value between valid outputs.

Top module: `volume_step_scaler`

## Requirements
- R1: A code `c` on `volCode` selects a Q2.14 multiplier g. The values are: 0→23143 (+3 dB), 1→16384 (0 dB), 2→11599, 3→8211, 4→5813, 5→4115, 6→2914, 7→2063 (-18 dB). Each step is a further 3 dB cut.
- R2: The scaled value is floor((x·g + 8192) / 16384): the product is rounded half toward positive infinity, with arithmetic shift semantics for negative products.
- R3: A scaled value above 4095 is output as 4095, and one below -4096 is output as -4096.
- R4: Each sample is scaled with the code presented in the same cycle as its `inValid`, even when the code changes on every back-to-back sample.
- R5: While `compandMode` is 1 at the valid cycle, the gain is 16384 (0 dB) whatever `volCode` holds.
- R6: While `muteIn` is 1 at the valid cycle, the output sample is exactly 0 and `outValid` is still asserted. Mute takes precedence over saturation and over companded mode.
- R7: `outValid` is high for exactly one cycle, two clock cycles after each cycle in which `inValid` is high, and is low otherwise.
- R8: After reset `outValid` is 0 and `outSample` is 0. In cycles with no valid output, `outSample` keeps the last value delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Strobe marking a sample on `inSample` |
| inSample | input | 13 | Two's-complement input sample |
| volCode | input | 3 | Gain code arriving with the sample |
| compandMode | input | 1 | 1 = companded mode, unity gain forced |
| muteIn | input | 1 | 1 = output silenced |
| outValid | output | 1 | Strobe marking a result on `outSample` |
| outSample | output | 13 | Rounded, saturated, possibly muted result |

## Verification
Mute and saturation can land in the same cycle. So can mute and the companded-mode override. The bench provokes the first with a full-scale sample at +3 dB with mute high, and the second with mute and companded mode raised together on the same valid cycle. Both are judged by the cycle-accurate reference model, which expects an exact zero with `outValid` high. Back-to-back samples with a new code each cycle test that every result is paired with its own code and never with its neighbour's.

// File: rtl/vsc_pkg.sv
package vsc_pkg;
  localparam int CODE_W = 3;
  localparam int GAIN_W = 16;
  localparam int FRAC_W = 14;
  localparam logic [CODE_W-1:0] UNITY_CODE = 3'd1;

  typedef struct packed {
    logic load;
    logic mute;
    logic [CODE_W-1:0] gainSel;
  } strobe_t;

  // Q2.14 multiplier per code: 3 dB steps from +3 dB down to -18 dB
  function automatic logic [GAIN_W-1:0] gainOf(input logic [CODE_W-1:0] code);
    case (code)
      3'd0: gainOf = 16'd23143;
      3'd1: gainOf = 16'd16384;
      3'd2: gainOf = 16'd11599;
      3'd3: gainOf = 16'd8211;
      3'd4: gainOf = 16'd5813;
      3'd5: gainOf = 16'd4115;
      3'd6: gainOf = 16'd2914;
      default: gainOf = 16'd2063;
    endcase
  endfunction
endpackage

// File: rtl/vsc_ctrl.sv
module vsc_ctrl
  import vsc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [CODE_W-1:0] volCode,
  input  logic              compandMode,
  input  logic              muteIn,
  output strobe_t           strb
);
  logic [CODE_W-1:0] effCode;

  // companded samples ignore their code
  assign effCode = compandMode ? UNITY_CODE : volCode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      strb <= '{load: 1'b0, mute: 1'b0, gainSel: UNITY_CODE};
    end else begin
      strb.load <= inValid;
      if (inValid) begin
        strb.mute    <= muteIn;
        strb.gainSel <= effCode;
      end
    end
  end

  // R5
  compand_unity_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && compandMode) |=> (strb.gainSel == UNITY_CODE));

  // R6
  mute_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && muteIn) |=> strb.mute);
endmodule

// File: rtl/vsc_datapath.sv
module vsc_datapath
  import vsc_pkg::*;
#(
  parameter int SAMPLE_W = 13
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       sampleEn,
  input  logic signed [SAMPLE_W-1:0] inSample,
  input  strobe_t                    strb,
  output logic                       outValid,
  output logic signed [SAMPLE_W-1:0] outSample
);
  localparam int PROD_W = SAMPLE_W + GAIN_W + 1;
  localparam logic signed [PROD_W-1:0] HALF_LSB =
    {{(PROD_W-FRAC_W){1'b0}}, 1'b1, {(FRAC_W-1){1'b0}}};
  localparam logic signed [PROD_W-1:0] SAT_MAX = PROD_W'((1 <<< (SAMPLE_W-1)) - 1);
  localparam logic signed [PROD_W-1:0] SAT_MIN = -SAT_MAX - PROD_W'(1);

  logic signed [SAMPLE_W-1:0] sampleReg;
  logic signed [GAIN_W:0]     gainS;
  logic signed [PROD_W-1:0]   prodFull;
  logic signed [PROD_W-1:0]   roundSum;
  logic signed [PROD_W-1:0]   shifted;
  logic signed [SAMPLE_W-1:0] satVal;
  logic signed [SAMPLE_W-1:0] nextOut;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sampleReg <= '0;
    else if (sampleEn) sampleReg <= inSample;
  end

  always_comb begin
    gainS    = signed'({1'b0, gainOf(strb.gainSel)});
    prodFull = PROD_W'(sampleReg) * PROD_W'(gainS);
    roundSum = prodFull + HALF_LSB;
    shifted  = roundSum >>> FRAC_W;
    if (shifted > SAT_MAX)      satVal = SAT_MAX[SAMPLE_W-1:0];
    else if (shifted < SAT_MIN) satVal = SAT_MIN[SAMPLE_W-1:0];
    else                        satVal = shifted[SAMPLE_W-1:0];
    nextOut = strb.mute ? '0 : satVal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      outSample <= '0;
    end else begin
      outValid <= strb.load;
      if (strb.load) outSample <= nextOut;
    end
  end

  // R7
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> outValid);

  // R7
  valid_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> !outValid);

  // R6
  mute_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && strb.mute) |=> (outSample == '0));

  // R8
  hold_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> $stable(outSample));
endmodule

// File: rtl/volume_step_scaler.sv
module volume_step_scaler
  import vsc_pkg::*;
#(
  parameter int SAMPLE_W = 13
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  input  logic [SAMPLE_W-1:0] inSample,
  input  logic [CODE_W-1:0]   volCode,
  input  logic                compandMode,
  input  logic                muteIn,
  output logic                outValid,
  output logic [SAMPLE_W-1:0] outSample
);
  strobe_t strb;
  logic signed [SAMPLE_W-1:0] outS;

  vsc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .volCode(volCode),
    .compandMode(compandMode), .muteIn(muteIn), .strb(strb)
  );

  vsc_datapath #(.SAMPLE_W(SAMPLE_W)) u_dp (
    .clk(clk), .rstN(rstN), .sampleEn(inValid), .inSample(signed'(inSample)),
    .strb(strb), .outValid(outValid), .outSample(outS)
  );

  assign outSample = outS;
endmodule

// File: tb/sim_volume_step_scaler.sv
module sim_volume_step_scaler;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [12:0] inSample = '0;
  logic [2:0] volCode = '0;
  logic compandMode = 1'b0;
  logic muteIn = 1'b0;
  logic outValid;
  logic [12:0] outSample;

  int total = 0;
  int bad = 0;
  bit done = 0;

  typedef struct { bit v; int s; string tag; } exp_t;
  exp_t p0, p1;
  int lastOut = 0;

  always #5 clk = ~clk;

  volume_step_scaler u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSample(inSample),
    .volCode(volCode), .compandMode(compandMode), .muteIn(muteIn),
    .outValid(outValid), .outSample(outSample)
  );

  // R1 table, written independently
  function automatic longint gainVal(int code);
    case (code)
      0: return 23143;
      1: return 16384;
      2: return 11599;
      3: return 8211;
      4: return 5813;
      5: return 4115;
      6: return 2914;
      default: return 2063;
    endcase
  endfunction

  // R2 rounding, R3 clamping
  function automatic int scaled(int s, int code);
    longint p = longint'(s) * gainVal(code);
    longint r = (p + 8192) >>> 14;
    if (r > 4095) r = 4095;
    if (r < -4096) r = -4096;
    return int'(r);
  endfunction

  function automatic int asSigned(logic [12:0] v);
    return int'(signed'(v));
  endfunction

  task automatic checkNow();
    int act = asSigned(outSample);
    total++;
    if (outValid !== p1.v) begin
      bad++;
      $display("FAIL %s/R7 valid: actual=%0d expected=%0d", p1.tag, outValid, p1.v);
    end
    total++;
    if (act != p1.s) begin
      bad++;
      $display("FAIL %s sample: actual=%0d expected=%0d", p1.v ? p1.tag : "R8", act, p1.s);
    end
  endtask

  task automatic step(bit v, int s, int code, bit comp, bit mute, string tag);
    int val;
    @(negedge clk);
    checkNow();
    p1 = p0;
    if (v) begin
      val = mute ? 0 : scaled(s, comp ? 1 : code);
      lastOut = val;
      p0 = '{1'b1, val, tag};
    end else begin
      p0 = '{1'b0, lastOut, tag};
    end
    inValid = v;
    inSample = 13'(s);
    volCode = 3'(code);
    compandMode = comp;
    muteIn = mute;
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    p0 = '{1'b0, 0, "R8"};
    p1 = '{1'b0, 0, "R8"};
    repeat (3) @(negedge clk);
    // R8 reset state
    total++;
    if (outValid !== 1'b0 || outSample !== 13'd0) begin
      bad++;
      $display("FAIL R8 reset: actual=%0d/%0d expected=0/0", outValid, outSample);
    end
    rstN = 1'b1;

    // R1: every code, positive and negative
    for (int c = 0; c < 8; c++) begin
      step(1, 1000, c, 0, 0, "R1");
      step(0, 77, (c + 3) % 8, 1, 1, "R8");
      step(1, -1000, c, 0, 0, "R1");
    end
    // R2: rounding corners
    step(1, 1, 2, 0, 0, "R2");
    step(1, -1, 0, 0, 0, "R2");
    step(1, 3, 2, 0, 0, "R2");
    step(1, -3, 6, 0, 0, "R2");
    step(1, 7, 7, 0, 0, "R2");
    step(1, -4096, 7, 0, 0, "R2");
    // R3: saturation at +3 dB
    step(1, 4095, 0, 0, 0, "R3");
    step(1, -4096, 0, 0, 0, "R3");
    step(1, 2900, 0, 0, 0, "R3");
    step(1, -2901, 0, 0, 0, "R3");
    // R4: code changes every back-to-back sample
    for (int i = 0; i < 16; i++) step(1, 1500 - i * 190, (i * 5) % 8, 0, 0, "R4");
    // R5: companded ignores code
    step(1, 4095, 0, 1, 0, "R5");
    step(1, -4096, 7, 1, 0, "R5");
    step(1, 1234, 3, 1, 0, "R5");
    // R6: mute, also with saturation and companded mode in the same cycle
    step(1, 4095, 0, 0, 1, "R6");
    step(1, -4096, 0, 1, 1, "R6");
    step(1, 500, 4, 0, 1, "R6");
    step(1, 500, 4, 0, 0, "R6");
    // R7/R8: gaps between samples, held output
    step(0, 999, 5, 0, 0, "R8");
    step(0, -999, 2, 0, 1, "R8");
    step(1, 800, 3, 0, 0, "R7");
    step(0, 0, 0, 0, 0, "R8");
    step(1, -800, 1, 0, 0, "R7");
    step(0, 0, 0, 0, 0, "R8");
    step(0, 0, 0, 0, 0, "R8");
    step(0, 0, 0, 0, 0, "R8");
    done = 1;
    summary();
    $finish;
  end
endmodule